// File: doc/BRIEF.md
# Serial Register Access Port (SPI Mode 3 Slave)

This block lets an external SPI master read and write a byte-wide register space of 128 locations. The pins (active-low select, serial clock, serial input, serial output with a separate output enable) are oversampled in the system clock domain through two-flop synchronizers. All frame decoding, register strobes and the shifting of read data take place on that clock. The register storage is outside the block. It sees an address, a one-cycle write strobe with data, and a one-cycle read strobe whose data it returns on the same cycle.

A frame starts with a direction bit: 0 selects a write and 1 selects a read. The 7-bit address follows, most significant bit first, and then one data byte, also most significant bit first. A write moves exactly one byte. Any clocks after the sixteenth change nothing. A read may run on for as long as select stays low. Each further group of eight clocks returns the byte at the next address, and the address wraps from 127 to 0. The output enable is raised only while read data is being shifted out. The serial input is ignored in that phase, so a 3-wire board can tie the input and output to one pad through the enable and use the same frame format and timing.

Top module: `spi_reg_port`

## Requirements
- R1: SPI mode 3 only. The serial clock idles high, the input bit is captured on its rising edge, and the serial output changes only while the serial clock is low (after a falling edge).
- R2: The first bit of a frame is the direction bit (0 = write, 1 = read). It is followed by 7 address bits and then the data bits, both most significant bit first.
- R3: A write frame of 16 clocks gives exactly one single-cycle write strobe, carrying the frame's address and data byte, after the sixteenth rising edge.
- R4: In a write frame, clocks after the sixteenth produce no further write strobe and change no register.
- R5: The output enable stays low for the whole of a write frame.
- R6: A read frame gives a read strobe for the frame's address and returns that byte on the serial output over clocks 9 to 16, most significant bit first.
- R7: In a read frame, while select stays low, each further 8 clocks return the byte at the previous address plus one.
- R8: The burst read address wraps from 127 to 0.
- R9: The output enable is low during the command bits of every frame and whenever select is high.
- R10: A frame that ends before its sixteenth clock makes no register write.
- R11: During read data phases the serial input is ignored. Toggling it changes neither the returned bytes nor any register.
- R12: After reset the output enable, write strobe and read strobe are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low select from the master |
| sck | input | 1 | Serial clock from the master, idles high |
| sdi | input | 1 | Serial data into the block |
| sdo | output | 1 | Serial data out of the block |
| sdoOe | output | 1 | Output enable for the serial output pad |
| regAddr | output | 7 | Register address |
| regWrData | output | 8 | Register write data |
| regWrEn | output | 1 | Single-cycle register write strobe |
| regRdEn | output | 1 | Single-cycle register read strobe |
| regRdData | input | 8 | Register read data, valid in the cycle of regRdEn |

## Verification
The assertions check on every cycle that the write strobe never lasts more than one cycle, that no strobe appears once a write frame has completed, and that the output enable stays low during write frames and while select is high. They also check that read and write strobes are never active together. The bench's scenarios are needed for the behaviour that depends on frame content. That covers the decoded address and data, the bytes returned in single and burst reads, the wrap from 127 to 0, the absence of writes in aborted frames, and the fact that the input pin has no effect during read data.

// File: rtl/spi_reg_port_pkg.sv
package spi_reg_port_pkg;

  parameter int ADDR_W = 7;
  parameter int DATA_W = 8;

  typedef enum logic [1:0] {
    PH_CMD   = 2'd0,
    PH_WDATA = 2'd1,
    PH_RDATA = 2'd2,
    PH_DONE  = 2'd3
  } phase_t;

  typedef struct packed {
    logic rxShift;   // shift captured input bit in
    logic rxBit;     // synchronized input bit
    logic addrLoad;  // last address bit has arrived
    logic addrInc;   // burst read moves to next address
    logic rdLoad;    // fetch register byte into output shifter
    logic txShift;   // present next output bit
    logic wrFire;    // issue register write
  } strobe_t;

endpackage

// File: rtl/spi_reg_port_ctrl.sv
module spi_reg_port_ctrl
  import spi_reg_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    csN,
  input  logic    sck,
  input  logic    sdi,
  output strobe_t stb,
  output logic    sdoOe
);

  localparam int CNT_MAX = (ADDR_W > DATA_W - 1) ? ADDR_W : DATA_W - 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  logic [SYNC_STAGES-1:0] csnSync, sckSync, sdiSync;
  logic csnS, sckS, sdiS, sckPrev;
  logic sckRise, sckFall;
  phase_t phase;
  logic [CNT_W-1:0] bitCnt;
  logic rwBit, rdLoadQ, wrFireQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csnSync <= '1;
      sckSync <= '1;
      sdiSync <= '0;
      sckPrev <= 1'b1;
    end else begin
      csnSync <= {csnSync[SYNC_STAGES-2:0], csN};
      sckSync <= {sckSync[SYNC_STAGES-2:0], sck};
      sdiSync <= {sdiSync[SYNC_STAGES-2:0], sdi};
      sckPrev <= sckS;
    end
  end

  assign csnS    = csnSync[SYNC_STAGES-1];
  assign sckS    = sckSync[SYNC_STAGES-1];
  assign sdiS    = sdiSync[SYNC_STAGES-1];
  assign sckRise = !csnS && sckS && !sckPrev;
  assign sckFall = !csnS && !sckS && sckPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_CMD;
      bitCnt  <= '0;
      rwBit   <= 1'b0;
      rdLoadQ <= 1'b0;
      wrFireQ <= 1'b0;
      sdoOe   <= 1'b0;
    end else begin
      rdLoadQ <= 1'b0;
      wrFireQ <= 1'b0;
      if (csnS) begin
        phase  <= PH_CMD;
        bitCnt <= '0;
        sdoOe  <= 1'b0;
      end else begin
        if (sckRise) begin
          bitCnt <= bitCnt + 1'b1;
          unique case (phase)
            PH_CMD: begin
              if (bitCnt == '0) rwBit <= sdiS;
              if (bitCnt == CMD_LAST) begin
                bitCnt  <= '0;
                phase   <= rwBit ? PH_RDATA : PH_WDATA;
                rdLoadQ <= rwBit;
              end
            end
            PH_WDATA: begin
              if (bitCnt == DATA_LAST) begin
                bitCnt  <= '0;
                phase   <= PH_DONE;
                wrFireQ <= 1'b1;
              end
            end
            PH_RDATA: begin
              if (bitCnt == DATA_LAST) begin
                bitCnt  <= '0;
                rdLoadQ <= 1'b1;
              end
            end
            PH_DONE: bitCnt <= bitCnt;
            default: bitCnt <= bitCnt;
          endcase
        end
        if (sckFall && phase == PH_RDATA) sdoOe <= 1'b1;
      end
    end
  end

  always_comb begin
    stb          = '0;
    stb.rxBit    = sdiS;
    stb.rxShift  = sckRise && (phase == PH_CMD || phase == PH_WDATA);
    stb.addrLoad = sckRise && phase == PH_CMD && bitCnt == CMD_LAST;
    stb.addrInc  = sckRise && phase == PH_RDATA && bitCnt == DATA_LAST;
    stb.txShift  = sckFall && phase == PH_RDATA;
    stb.rdLoad   = rdLoadQ;
    stb.wrFire   = wrFireQ;
  end

  // R3: a write strobe never lasts two cycles
  a_r3_single_write: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrFire |=> !stb.wrFire);

  // R4: once a write frame has completed, trailing clocks produce no strobe
  a_r4_no_strobe_after_write: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DONE && $past(phase == PH_DONE)) |-> !(stb.wrFire || stb.rdLoad));

  // R5: output enable stays low through write frames
  a_r5_no_oe_in_write: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_WDATA || phase == PH_DONE) |-> !sdoOe);

  // R9: output enable low while deselected
  a_r9_oe_idle: assert property (@(posedge clk) disable iff (!rstN)
    (csnS && $past(csnS)) |-> !sdoOe);

endmodule

// File: rtl/spi_reg_port_dp.sv
module spi_reg_port_dp
  import spi_reg_port_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] regRdData,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic              regWrEn,
  output logic              regRdEn,
  output logic              sdo
);

  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] rxShift, txShift;
  logic              sdoQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr    <= '0;
      rxShift <= '0;
      txShift <= '0;
      sdoQ    <= 1'b0;
    end else begin
      if (stb.rxShift) rxShift <= {rxShift[DATA_W-2:0], stb.rxBit};
      if (stb.addrLoad)     addr <= {rxShift[ADDR_W-2:0], stb.rxBit};
      else if (stb.addrInc) addr <= addr + 1'b1;
      if (stb.rdLoad) begin
        txShift <= regRdData;
      end else if (stb.txShift) begin
        sdoQ    <= txShift[DATA_W-1];
        txShift <= {txShift[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign regAddr   = addr;
  assign regWrData = rxShift;
  assign regWrEn   = stb.wrFire;
  assign regRdEn   = stb.rdLoad;
  assign sdo       = sdoQ;

  // R2: a frame is either a read or a write, never both at once
  a_r2_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regRdEn));

endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port
  import spi_reg_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdoOe,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic              regWrEn,
  output logic              regRdEn,
  input  logic [DATA_W-1:0] regRdData
);

  strobe_t stb;

  spi_reg_port_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .csN   (csN),
    .sck   (sck),
    .sdi   (sdi),
    .stb   (stb),
    .sdoOe (sdoOe)
  );

  spi_reg_port_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .regRdData (regRdData),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .sdo       (sdo)
  );

endmodule

// File: tb/spi_reg_port_bench.sv
module spi_reg_port_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sck = 1'b1, sdi = 1'b0;
  logic sdo, sdoOe, regWrEn, regRdEn;
  logic [6:0] regAddr;
  logic [7:0] regWrData, regRdData;

  logic [7:0] mem [0:127];
  logic [7:0] rxByte [0:7];
  int  nChecks = 0, nFails = 0, wrCount = 0, hiChange = 0;
  logic [6:0] lastWrAddr;
  logic [7:0] lastWrData;
  logic track = 1'b0, frameOe = 1'b0, cmdOe = 1'b0, sdoPrev = 1'b0;
  bit   finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_reg_port u_spi_reg_port (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .sdi(sdi),
    .sdo(sdo), .sdoOe(sdoOe), .regAddr(regAddr), .regWrData(regWrData),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regRdData(regRdData)
  );

  assign regRdData = mem[regAddr];

  always @(posedge clk) begin
    if (regWrEn) begin
      wrCount++;
      lastWrAddr = regAddr;
      lastWrData = regWrData;
      mem[regAddr] <= regWrData;
    end
  end

  always @(negedge clk) begin
    if (track && sdoOe) frameOe = 1'b1;
    if (sck && sdoOe && sdo !== sdoPrev) hiChange++;
    sdoPrev = sdo;
  end

  function automatic logic [7:0] initVal(input int a);
    return 8'((a * 7) + 3);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clockBit(input logic din, output logic dout, output logic oe);
    @(negedge clk);
    sck = 1'b0;
    sdi = din;
    repeat (HALF) @(negedge clk);
    dout = sdo;
    oe   = sdoOe;
    sck  = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic runFrame(input logic rw, input logic [6:0] addr,
                          input int nData, input logic [7:0] wbyte);
    logic [7:0] cmd;
    logic d, o;
    cmd = {rw, addr};
    frameOe = 1'b0;
    cmdOe = 1'b0;
    track = 1'b1;
    @(negedge clk);
    csN = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      clockBit(cmd[7-i], d, o);
      if (o) cmdOe = 1'b1;
    end
    for (int b = 0; b < nData; b++) begin
      clockBit(wbyte[7 - (b % 8)], d, o);
      rxByte[b / 8][7 - (b % 8)] = d;
    end
    repeat (HALF) @(negedge clk);
    csN = 1'b1;
    repeat (4 * HALF) @(negedge clk);
    track = 1'b0;
  endtask

  task automatic testReset();
    chk(sdoOe == 1'b0, "R12 oe after reset", int'(sdoOe), 0);
    chk(regWrEn == 1'b0 && regRdEn == 1'b0, "R12 strobes after reset",
        int'({regWrEn, regRdEn}), 0);
  endtask

  task automatic testWrite();
    int w0 = wrCount;
    runFrame(1'b0, 7'h15, 8, 8'hA5);
    chk(wrCount - w0 == 1, "R3 write count", wrCount - w0, 1);
    chk(lastWrAddr == 7'h15, "R2 write address", int'(lastWrAddr), 'h15);
    chk(lastWrData == 8'hA5, "R3 write data", int'(lastWrData), 'hA5);
    chk(!frameOe, "R5 oe during write", int'(frameOe), 0);
  endtask

  task automatic testLongWrite();
    int w0 = wrCount;
    runFrame(1'b0, 7'h40, 24, 8'h3C);
    chk(wrCount - w0 == 1, "R4 extra clocks no second write", wrCount - w0, 1);
    chk(mem[7'h40] == 8'h3C, "R4 register holds first byte", int'(mem[7'h40]), 'h3C);
    chk(!frameOe, "R5 oe during long write", int'(frameOe), 0);
  endtask

  task automatic testRead();
    runFrame(1'b1, 7'h15, 8, 8'h00);
    chk(rxByte[0] == 8'hA5, "R6 single read byte", int'(rxByte[0]), 'hA5);
    chk(!cmdOe, "R9 oe during command bits", int'(cmdOe), 0);
    chk(frameOe, "R6 oe raised for read data", int'(frameOe), 1);
    chk(sdoOe == 1'b0, "R9 oe after select high", int'(sdoOe), 0);
  endtask

  task automatic testBurst();
    runFrame(1'b1, 7'h10, 32, 8'h00);
    for (int k = 0; k < 4; k++)
      chk(rxByte[k] == initVal(16 + k), "R7 burst byte", int'(rxByte[k]), int'(initVal(16 + k)));
  endtask

  task automatic testWrap();
    runFrame(1'b1, 7'h7E, 24, 8'h00);
    chk(rxByte[0] == initVal(126), "R8 byte at 126", int'(rxByte[0]), int'(initVal(126)));
    chk(rxByte[1] == initVal(127), "R8 byte at 127", int'(rxByte[1]), int'(initVal(127)));
    chk(rxByte[2] == initVal(0), "R8 wrapped byte at 0", int'(rxByte[2]), int'(initVal(0)));
  endtask

  task automatic testAbort();
    int w0 = wrCount;
    runFrame(1'b0, 7'h20, 4, 8'hFF);
    chk(wrCount == w0, "R10 short frame no write", wrCount - w0, 0);
    runFrame(1'b0, 7'h21, 7, 8'hFF);
    chk(wrCount == w0, "R10 fifteen clocks no write", wrCount - w0, 0);
    chk(mem[7'h21] == initVal(33), "R10 register unchanged", int'(mem[7'h21]), int'(initVal(33)));
  endtask

  task automatic testIgnoreInput();
    int w0 = wrCount;
    runFrame(1'b1, 7'h40, 16, 8'hFF);
    chk(rxByte[0] == 8'h3C, "R11 read with input high", int'(rxByte[0]), 'h3C);
    chk(rxByte[1] == initVal(65), "R11 burst with input high", int'(rxByte[1]), int'(initVal(65)));
    chk(wrCount == w0, "R11 no write during read", wrCount - w0, 0);
  endtask

  initial begin
    for (int a = 0; a < 128; a++) mem[a] = initVal(a);
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    testReset();
    testWrite();
    testLongWrite();
    testRead();
    testBurst();
    testWrap();
    testAbort();
    testIgnoreInput();
    chk(hiChange == 0, "R1 output changed while clock high", hiChange, 0);
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule